// File: doc/BRIEF.md
# Character Display Command Executor

This block carries out the command and data bytes that a character display controller receives from its host bus. A bus front end hands over one byte at a time, together with a register-select bit and a read/write bit. Instruction bytes are sorted by the position of their highest set bit. Each instruction updates the controller state: the address counter and the address space it points into (display text memory or glyph memory), the entry mode, the display, cursor and blink enables, the display shift offset, and the function settings. Data bytes are written to, or read from, the selected memory at the address counter. After each data access the counter steps up or down.

Every accepted instruction or data access starts a busy period whose length is counted in oscillator cycles. Clear and home use a long period; all other operations use a short one. A clear also sweeps the whole display memory with the blank code while it is busy. The memories are outside the block and are reached through one combinational-read port with a single write strobe. The scan logic reads the state outputs directly.

The command input is a valid/ready stream. `in_ready` falls while the block is busy, except for a status read, which is always taken. If the source drops `in_valid` before `in_ready` rises, its byte is discarded and has no effect. Read results come back as a one-cycle `out_valid` pulse with no back-pressure, so the sink must take them on that cycle.

Top module: `lcd_cmd_exec`

## Requirements
- R1: After reset the state is as follows. Address counter 0 in display space. Increment on. Entry shift off. Display, cursor and blink off. 8-bit bus on. One-line mode. 5x8 font. Shift offset 0. Busy low.
- R2: `in_ready` is low while busy for any byte except a status read (`in_rs`=0, `in_rd`=1). A status read is accepted at any time and does not start a busy period. One cycle after acceptance it returns `out_byte` = {busy, address counter}. A byte that is offered while busy and then withdrawn changes nothing.
- R3: An instruction (`in_rs`=0, `in_rd`=0) is decoded by its highest set bit alone, and the lower bits below each field are ignored. The byte 0x00 has no effect and raises no busy.
- R4: Clear (highest bit 0) writes 0x20 to all 80 display locations, sets the address counter to 0 in display space, sets the offset to 0, and leaves glyph memory unchanged.
- R5: Home (highest bit 1) sets the address counter to 0 in display space and the offset to 0. It leaves memory contents unchanged.
- R6: Bit 2 selects entry mode: bit 1 = increment, bit 0 = shift on access. Bit 3 selects the enables: bit 2 = display, bit 1 = cursor, bit 0 = blink. Bit 5 selects the function settings: bit 4 = 8-bit bus, bit 3 = two-line, bit 2 = 5x10 font. A function set resets the offset to 0.
- R7: Highest bit 4 with bit 3 = 0 moves the address counter one step: right (up) when bit 2 = 1. With bit 3 = 1 it shifts the display. A left shift adds 1 to the offset and a right shift subtracts 1, modulo 80 in one-line mode and modulo 40 in two-line mode.
- R8: Highest bit 6 loads bits 5:0 as a glyph-memory address. Highest bit 7 loads bits 6:0 as a display address. Data accesses then go to the space that was loaded last.
- R9: A data write (`in_rs`=1, `in_rd`=0) stores `in_byte` at the address counter. A data read (`in_rs`=1, `in_rd`=1) returns the stored byte on `out_byte` one cycle later. Both then step the counter in the entry direction.
- R10: Address stepping wraps as follows. One-line mode: 0x4F up to 0x00. Two-line mode: 0x27 up to 0x40 and 0x67 up to 0x00, with the reverse steps when counting down. Glyph space wraps modulo 64.
- R11: With entry shift on, each data access in display space also moves the offset: +1 when incrementing, -1 when decrementing. Accesses in glyph space leave the offset unchanged.
- R12: Busy stays high for exactly 886 cycles after clear or home, and for 22 cycles after any other instruction or data access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Byte taken this cycle when valid |
| in_rs | input | 1 | 1 = data register, 0 = instruction/status |
| in_rd | input | 1 | 1 = read, 0 = write |
| in_byte | input | 8 | Instruction or write data |
| out_valid | output | 1 | One-cycle read result pulse |
| out_byte | output | 8 | Read data or {busy, address counter} |
| ram_we | output | 1 | Memory write strobe |
| ram_cg | output | 1 | 1 = glyph memory, 0 = display memory |
| ram_addr | output | 7 | Memory address |
| ram_wdata | output | 8 | Memory write data |
| ram_rdata | input | 8 | Combinational read data at ram_addr |
| busy | output | 1 | Operation in progress |
| addr_cnt | output | 7 | Address counter |
| cg_mode | output | 1 | Counter points into glyph memory |
| entry_inc | output | 1 | Step direction is up |
| entry_shift | output | 1 | Shift display on data access |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Blink enable |
| shift_ofs | output | 7 | Display shift offset |
| bus_8bit | output | 1 | Host bus width setting |
| two_line | output | 1 | Two-line mode |
| font_tall | output | 1 | 5x10 font |

## Verification
The assertions check the handshake rules on every cycle. They confirm that ready follows busy and that status reads are always taken. They check that every accepted data access raises busy, that a read pulse only follows an accepted read, and that the address state holds still during a busy period. They also check that glyph addresses stay below 64 and that writes outside an accepted byte are blank-code writes to display memory. Only the bench scenarios can show the exact busy lengths, the wrap points of the two line layouts, the offset arithmetic, and the memory contents left by clear, home and withdrawn bytes.

// File: rtl/lcd_exec_pkg.sv
package lcd_exec_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_DISP,
    OP_SHIFT,
    OP_FUNC,
    OP_CGADR,
    OP_DDADR
  } op_e;

  // Opcode class chosen by the position of the highest set bit.
  function automatic op_e op_of_bit(input int pos);
    case (pos)
      0:       return OP_CLEAR;
      1:       return OP_HOME;
      2:       return OP_ENTRY;
      3:       return OP_DISP;
      4:       return OP_SHIFT;
      5:       return OP_FUNC;
      6:       return OP_CGADR;
      default: return OP_DDADR;
    endcase
  endfunction

  // One address step in the current space and line layout.
  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic              up,
    input logic              cg,
    input logic              two,
    input int                dd_depth,
    input int                cg_depth,
    input int                base2
  );
    int v;
    int ll;
    v  = int'(a);
    ll = dd_depth / 2;
    if (cg)
      v = up ? (v + 1) % cg_depth : (v + cg_depth - 1) % cg_depth;
    else if (!two)
      v = up ? ((v == dd_depth - 1) ? 0 : v + 1)
             : ((v == 0) ? dd_depth - 1 : v - 1);
    else if (up)
      v = (v == ll - 1) ? base2 : ((v == base2 + ll - 1) ? 0 : v + 1);
    else
      v = (v == 0) ? base2 + ll - 1 : ((v == base2) ? ll - 1 : v - 1);
    return ADDR_W'(v);
  endfunction

endpackage

// File: rtl/lcd_exec_decode.sv
module lcd_exec_decode
  import lcd_exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] code,
  output op_e          op
);
  // Scan upward so that the highest set bit decides.
  always_comb begin
    op = OP_NONE;
    for (int i = 0; i < W; i++)
      if (code[i]) op = op_of_bit(i);
  end
endmodule

// File: rtl/lcd_exec_addr.sv
module lcd_exec_addr
  import lcd_exec_pkg::*;
#(
  parameter int DD_DEPTH   = 80,
  parameter int CG_DEPTH   = 64,
  parameter int LINE2_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_cg,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic              step_up,
  input  logic              two_line,
  output logic [ADDR_W-1:0] ac,
  output logic              cg
);
  logic [ADDR_W-1:0] ac_next;

  always_comb
    ac_next = step_addr(ac, step_up, cg, two_line, DD_DEPTH, CG_DEPTH, LINE2_BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac <= '0;
      cg <= 1'b0;
    end else if (load) begin
      ac <= load_val;
      cg <= load_cg;
    end else if (step) begin
      ac <= ac_next;
    end
  end
endmodule

// File: rtl/lcd_exec_timer.sv
module lcd_exec_timer
  import lcd_exec_pkg::*;
#(
  parameter int CLR_CYC    = 886,
  parameter int EXE_CYC    = 22,
  parameter int DD_DEPTH   = 80,
  parameter int CG_DEPTH   = 64,
  parameter int LINE2_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_long,
  input  logic              start_clear,
  input  logic              two_line,
  output logic              busy,
  output logic              sweep_we,
  output logic [ADDR_W-1:0] sweep_addr
);
  localparam int CW = $clog2(CLR_CYC + 1);
  localparam int SW = $clog2(DD_DEPTH + 1);

  logic [CW-1:0] cnt;
  logic [SW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start)
      cnt <= start_long ? CW'(CLR_CYC) : CW'(EXE_CYC);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  // Blank sweep walks the display addresses in the current layout.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left       <= '0;
      sweep_addr <= '0;
    end else if (start_clear) begin
      left       <= SW'(DD_DEPTH);
      sweep_addr <= '0;
    end else if (left != '0) begin
      left       <= left - 1'b1;
      sweep_addr <= step_addr(sweep_addr, 1'b1, 1'b0, two_line,
                              DD_DEPTH, CG_DEPTH, LINE2_BASE);
    end
  end

  assign busy     = (cnt != '0);
  assign sweep_we = (left != '0);
endmodule

// File: rtl/lcd_cmd_exec.sv
module lcd_cmd_exec
  import lcd_exec_pkg::*;
#(
  parameter int          DD_DEPTH   = 80,
  parameter int          CG_DEPTH   = 64,
  parameter int          LINE2_BASE = 64,
  parameter int          CLR_CYC    = 886,
  parameter int          EXE_CYC    = 22,
  parameter logic [7:0]  BLANK      = 8'h20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_rs,
  input  logic                in_rd,
  input  logic [DATA_W-1:0]   in_byte,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_byte,
  output logic                ram_we,
  output logic                ram_cg,
  output logic [ADDR_W-1:0]   ram_addr,
  output logic [DATA_W-1:0]   ram_wdata,
  input  logic [DATA_W-1:0]   ram_rdata,
  output logic                busy,
  output logic [ADDR_W-1:0]   addr_cnt,
  output logic                cg_mode,
  output logic                entry_inc,
  output logic                entry_shift,
  output logic                disp_on,
  output logic                cursor_on,
  output logic                blink_on,
  output logic [ADDR_W-1:0]   shift_ofs,
  output logic                bus_8bit,
  output logic                two_line,
  output logic                font_tall
);
  localparam logic [ADDR_W-1:0] OFS_MAX1 = ADDR_W'(DD_DEPTH - 1);
  localparam logic [ADDR_W-1:0] OFS_MAX2 = ADDR_W'(DD_DEPTH / 2 - 1);
  localparam int                CG_AW    = $clog2(CG_DEPTH);

  op_e               op;
  logic              status_rd, accept, instr, dacc;
  logic              ac_load, ac_load_cg, ac_step, ac_up;
  logic [ADDR_W-1:0] ac_load_val;
  logic              t_start, t_long, t_clear;
  logic              sweep_we;
  logic [ADDR_W-1:0] sweep_addr;
  logic [ADDR_W-1:0] ofs_max, ofs_up, ofs_dn;

  lcd_exec_decode #(.W(DATA_W)) u_dec (
    .code (in_byte),
    .op   (op)
  );

  assign status_rd = !in_rs && in_rd;
  assign in_ready  = !busy || status_rd;
  assign accept    = in_valid && in_ready;
  assign instr     = accept && !in_rs && !in_rd;
  assign dacc      = accept && in_rs;

  always_comb begin
    ac_load     = 1'b0;
    ac_load_cg  = 1'b0;
    ac_load_val = '0;
    ac_step     = dacc;
    ac_up       = entry_inc;
    if (instr) begin
      unique case (op)
        OP_CLEAR, OP_HOME: ac_load = 1'b1;
        OP_CGADR: begin
          ac_load     = 1'b1;
          ac_load_cg  = 1'b1;
          ac_load_val = ADDR_W'(in_byte[CG_AW-1:0]);
        end
        OP_DDADR: begin
          ac_load     = 1'b1;
          ac_load_val = in_byte[ADDR_W-1:0];
        end
        OP_SHIFT: begin
          ac_step = !in_byte[3];
          ac_up   = in_byte[2];
        end
        default: ;
      endcase
    end
  end

  lcd_exec_addr #(
    .DD_DEPTH(DD_DEPTH), .CG_DEPTH(CG_DEPTH), .LINE2_BASE(LINE2_BASE)
  ) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ac_load),
    .load_cg  (ac_load_cg),
    .load_val (ac_load_val),
    .step     (ac_step),
    .step_up  (ac_up),
    .two_line (two_line),
    .ac       (addr_cnt),
    .cg       (cg_mode)
  );

  assign t_start = dacc || (instr && op != OP_NONE);
  assign t_long  = instr && (op == OP_CLEAR || op == OP_HOME);
  assign t_clear = instr && op == OP_CLEAR;

  lcd_exec_timer #(
    .CLR_CYC(CLR_CYC), .EXE_CYC(EXE_CYC), .DD_DEPTH(DD_DEPTH),
    .CG_DEPTH(CG_DEPTH), .LINE2_BASE(LINE2_BASE)
  ) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (t_start),
    .start_long  (t_long),
    .start_clear (t_clear),
    .two_line    (two_line),
    .busy        (busy),
    .sweep_we    (sweep_we),
    .sweep_addr  (sweep_addr)
  );

  // Offset counts left shifts; the window is one line in two-line mode.
  assign ofs_max = two_line ? OFS_MAX2 : OFS_MAX1;
  assign ofs_up  = (shift_ofs >= ofs_max) ? '0 : shift_ofs + 1'b1;
  assign ofs_dn  = (shift_ofs == '0) ? ofs_max : shift_ofs - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_inc   <= 1'b1;
      entry_shift <= 1'b0;
      disp_on     <= 1'b0;
      cursor_on   <= 1'b0;
      blink_on    <= 1'b0;
      bus_8bit    <= 1'b1;
      two_line    <= 1'b0;
      font_tall   <= 1'b0;
      shift_ofs   <= '0;
    end else if (instr) begin
      unique case (op)
        OP_CLEAR, OP_HOME: shift_ofs <= '0;
        OP_ENTRY: begin
          entry_inc   <= in_byte[1];
          entry_shift <= in_byte[0];
        end
        OP_DISP: begin
          disp_on   <= in_byte[2];
          cursor_on <= in_byte[1];
          blink_on  <= in_byte[0];
        end
        OP_SHIFT:
          if (in_byte[3]) shift_ofs <= in_byte[2] ? ofs_dn : ofs_up;
        OP_FUNC: begin
          bus_8bit  <= in_byte[4];
          two_line  <= in_byte[3];
          font_tall <= in_byte[2];
          shift_ofs <= '0;
        end
        default: ;
      endcase
    end else if (dacc && entry_shift && !cg_mode) begin
      shift_ofs <= entry_inc ? ofs_up : ofs_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= accept && in_rd;
      if (accept && in_rd)
        out_byte <= in_rs ? ram_rdata : {busy, addr_cnt};
    end
  end

  assign ram_we    = sweep_we || (dacc && !in_rd);
  assign ram_cg    = sweep_we ? 1'b0 : cg_mode;
  assign ram_addr  = sweep_we ? sweep_addr : addr_cnt;
  assign ram_wdata = sweep_we ? BLANK : in_byte;
endmodule

// File: rtl/lcd_cmd_exec_chk.sv
module lcd_cmd_exec_chk #(
  parameter int         CG_DEPTH = 64,
  parameter logic [7:0] BLANK    = 8'h20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_rs,
  input logic       in_rd,
  input logic       out_valid,
  input logic       ram_we,
  input logic       ram_cg,
  input logic [7:0] ram_wdata,
  input logic       busy,
  input logic [6:0] addr_cnt,
  input logic       cg_mode
);
  a_r2_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);

  a_r2_status_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rs && in_rd) |-> in_ready);

  a_r12_data_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_rs) |=> busy);

  a_r9_read_pulse_source: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_ready && in_rd));

  a_r10_cg_range: assert property (@(posedge clk) disable iff (!rst_n)
    cg_mode |-> (int'(addr_cnt) < CG_DEPTH));

  a_r8_addr_holds_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(in_valid && in_ready)) |=> ($stable(addr_cnt) && $stable(cg_mode)));

  a_r4_sweep_writes_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && !(in_valid && in_ready)) |-> (!ram_cg && ram_wdata == BLANK));
endmodule

bind lcd_cmd_exec lcd_cmd_exec_chk #(.CG_DEPTH(CG_DEPTH), .BLANK(BLANK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_rs     (in_rs),
  .in_rd     (in_rd),
  .out_valid (out_valid),
  .ram_we    (ram_we),
  .ram_cg    (ram_cg),
  .ram_wdata (ram_wdata),
  .busy      (busy),
  .addr_cnt  (addr_cnt),
  .cg_mode   (cg_mode)
);

// File: tb/sim_lcd_cmd_exec.sv
`timescale 1ns/1ps
module sim_lcd_cmd_exec;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_rs = 1'b0, in_rd = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_ready, out_valid, ram_we, ram_cg, busy, cg_mode;
  logic [7:0] out_byte, ram_wdata, ram_rdata;
  logic [6:0] ram_addr, addr_cnt, shift_ofs;
  logic       entry_inc, entry_shift, disp_on, cursor_on, blink_on;
  logic       bus_8bit, two_line, font_tall;

  logic [7:0] dd_mem [128];
  logic [7:0] cg_mem [64];

  int checks = 0, fails = 0;
  int busy_n;
  logic       got_v;
  logic [7:0] got_b;

  always #4 clk = ~clk;

  lcd_cmd_exec u0 (.*);

  assign ram_rdata = ram_cg ? cg_mem[ram_addr[5:0]] : dd_mem[ram_addr];
  always @(posedge clk)
    if (ram_we) begin
      if (ram_cg) cg_mem[ram_addr[5:0]] <= ram_wdata;
      else        dd_mem[ram_addr]      <= ram_wdata;
    end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ceq(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // Offer one byte; optionally wait for the busy period to end, counting it.
  task automatic send(input logic rs, input logic rd, input logic [7:0] b, input bit wait_idle = 1);
    @(negedge clk);
    in_rs = rs; in_rd = rd; in_byte = b;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got_v = out_valid;
    got_b = out_byte;
    busy_n = 0;
    if (wait_idle)
      while (busy) begin
        busy_n++;
        @(negedge clk);
      end
  endtask

  // {rs, rd, byte, expected counter, expected glyph-space flag}
  localparam int NV = 18;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hCF, 7'h4F, 1'b0},
    {1'b1, 1'b0, 8'h41, 7'h00, 1'b0},
    {1'b0, 1'b0, 8'h04, 7'h00, 1'b0},
    {1'b1, 1'b0, 8'h42, 7'h4F, 1'b0},
    {1'b0, 1'b0, 8'h06, 7'h4F, 1'b0},
    {1'b0, 1'b0, 8'h7F, 7'h3F, 1'b1},
    {1'b1, 1'b0, 8'h1F, 7'h00, 1'b1},
    {1'b0, 1'b0, 8'h10, 7'h3F, 1'b1},
    {1'b0, 1'b0, 8'h14, 7'h00, 1'b1},
    {1'b0, 1'b0, 8'h38, 7'h00, 1'b1},
    {1'b0, 1'b0, 8'hA7, 7'h27, 1'b0},
    {1'b1, 1'b0, 8'h43, 7'h40, 1'b0},
    {1'b0, 1'b0, 8'hE7, 7'h67, 1'b0},
    {1'b1, 1'b0, 8'h44, 7'h00, 1'b0},
    {1'b0, 1'b0, 8'h10, 7'h67, 1'b0},
    {1'b0, 1'b0, 8'hC0, 7'h40, 1'b0},
    {1'b0, 1'b0, 8'h10, 7'h27, 1'b0},
    {1'b0, 1'b0, 8'h02, 7'h00, 1'b0}
  };

  initial begin
    for (int i = 0; i < 128; i++) dd_mem[i] = 8'h00;
    for (int i = 0; i < 64; i++)  cg_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    ceq("R1 addr_cnt", addr_cnt, 0);
    ceq("R1 flags", {cg_mode, entry_inc, entry_shift, disp_on, cursor_on, blink_on,
                     bus_8bit, two_line, font_tall, busy}, 10'b0100001000);
    ceq("R1 shift_ofs", shift_ofs, 0);

    // R8 R9 R10 table walk: address loads, data writes and wraps
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][17], VEC[v][16], VEC[v][15:8]);
      ceq($sformatf("R10 vec%0d addr_cnt", v), addr_cnt, VEC[v][7:1]);
      ceq($sformatf("R8 vec%0d cg_mode", v), cg_mode, VEC[v][0]);
    end
    ceq("R9 dd[4F]", dd_mem[7'h4F], 8'h41);
    ceq("R9 dd[00]", dd_mem[7'h00], 8'h42);
    ceq("R8 cg[3F]", cg_mem[6'h3F], 8'h1F);
    ceq("R10 dd[27]", dd_mem[7'h27], 8'h43);
    ceq("R10 dd[67]", dd_mem[7'h67], 8'h44);

    // R9 data read returns stored byte, then steps
    send(1'b0, 1'b0, 8'hA7);
    send(1'b1, 1'b1, 8'h00);
    ceq("R9 read valid", got_v, 1);
    ceq("R9 read data", got_b, 8'h43);
    ceq("R9 read step", addr_cnt, 7'h40);
    ceq("R12 read busy", busy_n, 22);

    // R6 function set fields, R12 short busy
    send(1'b0, 1'b0, 8'h24);
    ceq("R12 func busy", busy_n, 22);
    ceq("R6 func", {bus_8bit, two_line, font_tall}, 3'b001);
    send(1'b0, 1'b0, 8'h38);
    ceq("R6 func2", {bus_8bit, two_line, font_tall}, 3'b110);

    // R3 zero byte has no effect, leading-one decode
    send(1'b0, 1'b0, 8'h00);
    ceq("R3 zero busy", busy_n, 0);
    ceq("R3 zero state", {addr_cnt, disp_on, cursor_on, blink_on}, {7'h40, 3'b000});
    send(1'b0, 1'b0, 8'h0D);
    ceq("R6 disp 0D", {disp_on, cursor_on, blink_on}, 3'b101);
    send(1'b0, 1'b0, 8'h0B);
    ceq("R3 disp 0B", {disp_on, cursor_on, blink_on}, 3'b011);

    // R7 display shift in two-line window
    send(1'b0, 1'b0, 8'h18);
    ceq("R7 left ofs", shift_ofs, 1);
    ceq("R7 left keeps ac", addr_cnt, 7'h40);
    send(1'b0, 1'b0, 8'h1C);
    ceq("R7 right ofs", shift_ofs, 0);
    send(1'b0, 1'b0, 8'h1F);
    ceq("R7 right wrap", shift_ofs, 39);

    // R11 entry shift on data access
    send(1'b0, 1'b0, 8'h07);
    send(1'b0, 1'b0, 8'h80);
    send(1'b1, 1'b0, 8'h55);
    ceq("R11 inc ofs", shift_ofs, 0);
    ceq("R11 inc ac", addr_cnt, 1);
    send(1'b0, 1'b0, 8'h05);
    send(1'b1, 1'b0, 8'h56);
    ceq("R11 dec ofs", shift_ofs, 39);
    ceq("R11 dec ac", addr_cnt, 0);
    send(1'b0, 1'b0, 8'h40);
    send(1'b1, 1'b0, 8'h66);
    ceq("R11 cg no shift", shift_ofs, 39);
    ceq("R10 cg down wrap", addr_cnt, 63);
    send(1'b0, 1'b0, 8'h06);

    // R5 home: long busy, counter and offset reset, contents kept
    send(1'b0, 1'b0, 8'h03);
    ceq("R12 home busy", busy_n, 886);
    ceq("R5 home ac", {cg_mode, addr_cnt}, 0);
    ceq("R5 home ofs", shift_ofs, 0);
    ceq("R5 home keeps dd", dd_mem[1], 8'h56);

    // R2 status read during busy, withdrawn write ignored
    send(1'b0, 1'b0, 8'h02, 0);
    send(1'b0, 1'b1, 8'h00, 0);
    ceq("R2 status valid", got_v, 1);
    ceq("R2 status byte", got_b, 8'h80);
    @(negedge clk);
    in_rs = 1'b1; in_rd = 1'b0; in_byte = 8'h77; in_valid = 1'b1;
    @(negedge clk);
    ceq("R2 ready low busy", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    while (busy) @(negedge clk);
    ceq("R2 withdrawn no write", dd_mem[0], 8'h55);
    send(1'b0, 1'b1, 8'h00);
    ceq("R2 idle status", got_b, 8'h00);
    ceq("R2 status no busy", busy_n, 0);

    // R4 clear
    send(1'b0, 1'b0, 8'h18);
    send(1'b1, 1'b0, 8'h99);
    send(1'b0, 1'b0, 8'h01);
    ceq("R12 clear busy", busy_n, 886);
    ceq("R4 clr dd[00]", dd_mem[7'h00], 8'h20);
    ceq("R4 clr dd[27]", dd_mem[7'h27], 8'h20);
    ceq("R4 clr dd[40]", dd_mem[7'h40], 8'h20);
    ceq("R4 clr dd[67]", dd_mem[7'h67], 8'h20);
    ceq("R4 clr keeps cg", cg_mem[6'h3F], 8'h1F);
    ceq("R4 clr state", {cg_mode, addr_cnt, shift_ofs}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule